// File: doc/BRIEF.md
# Clock-Stop SPI Master Engine

This block is a serial transfer engine that acts as the bus master in an SPI clock-stop arrangement. Its serial clock comes from the system clock through a programmable divider. High time and low time are split by a fixed rule that depends on whether the divider value is odd or even. The serial clock rests low between words and runs only while a word is in flight.

A transfer begins when a start strobe is seen while the engine is idle. The divider value, the word length and the transmit word are captured on that cycle. The active-low slave select drops a full serial-clock period before the first rising edge. The first data bit appears on the output line one high-time after select drops. Each later bit appears just after a falling edge, and the word goes out most significant bit first. On every rising edge the engine samples the input line into a shift register.

After the falling edge of the last bit, the engine releases the output line to high impedance. It keeps select low for one more low-time. Select then rises, the received word is presented, and a one-cycle completion pulse is raised.

Top module: `spim_master`

## Requirements
- R1: For an even divider value D greater than zero, the serial clock is high for D/2+1 system cycles and low for D/2 system cycles, giving a period of D+1 cycles.
- R2: For an odd divider value D, the serial clock is high for (D+1)/2 cycles and low for (D+1)/2 cycles.
- R3: A divider value of zero gives a serial clock that is high for one cycle and low for one cycle.
- R4: The serial clock is low and the slave select is high whenever no word is in progress. The slave select falls exactly one serial period (high plus low time) before the first rising serial-clock edge.
- R5: The output enable rises exactly one high-time after slave select falls, carrying bit n-1 of the transmit word. The remaining bits follow in descending order, and each one changes on the cycle in which the serial clock falls.
- R6: The input line is sampled on each rising serial-clock edge. When the word completes, the receive output holds the n samples, with the first sample in bit n-1 and the last in bit 0.
- R7: On the cycle in which the last bit's falling edge occurs, the output enable drops and the data output goes to high impedance. Slave select rises exactly one low-time later.
- R8: The completion flag is high for exactly one cycle, which is the cycle in which slave select returns high, and is low at all other times.
- R9: The word length input gives the number of bits n. Values below 8 act as 8 and values above 32 act as 32, so a word has exactly n rising serial-clock edges.
- R10: A start strobe that arrives while a word is in progress is ignored. The current word completes with its captured data, and no further word follows.
- R11: After reset, the slave select is high, the serial clock is low, the data output is at high impedance, and both the completion and busy flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider's input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Divider value, captured at start |
| len_i | input | LEN_W | Word length in bits, captured at start |
| start_i | input | 1 | Start strobe, accepted only while idle |
| tx_word_i | input | MAX_LEN | Transmit word, right-aligned |
| rx_word_o | output | MAX_LEN | Received word, right-aligned, valid from the completion pulse |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High while a word is in progress |
| sclk_o | output | 1 | Serial clock, idle low |
| nss_o | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data out, high impedance when disabled |
| mosi_oe_o | output | 1 | Output enable for the serial data line |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest case to reach is the narrow window at the end of a word. The last falling edge, the release of the data line, the held select and the completion pulse all fall within one low-time, and that window is a single cycle when the divider value is 0, 1 or 2. The scoreboard monitor timestamps every select, enable and clock transition. It checks each interval against widths it derives on its own from the captured divider value. A slave model answers on the falling edges so that every sampled bit can be checked.

Separate runs cover even, odd and zero divider values, clamped word lengths at both ends, and a second start strobe injected in the middle of a word. After that last run, the monitor checks that select stays high and that the queue of expected words is empty.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_HIGH,
        SQ_LOW,
        SQ_TAIL
    } spim_phase_e;
endpackage

// File: rtl/spim_timing.sv
module spim_timing #(
    parameter int unsigned DIV_W = 8,
    localparam int unsigned CW = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div_i,
    output logic [CW-1:0]    hi_o,
    output logic [CW-1:0]    lo_o
);
    logic [CW-1:0] half_up;
    logic [CW-1:0] half_dn;

    always_comb begin
        half_up = ({1'b0, div_i} + CW'(1)) >> 1;
        half_dn = {1'b0, div_i} >> 1;
        if (div_i == '0) begin
            hi_o = CW'(1);
            lo_o = CW'(1);
        end else if (div_i[0]) begin
            hi_o = half_up;
            lo_o = half_up;
        end else begin
            hi_o = half_dn + CW'(1);
            lo_o = half_dn;
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned LEN_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [MAX_LEN-1:0] tx_word_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               shift_i,
    input  logic               sample_i,
    input  logic               finish_i,
    input  logic               miso_i,
    output logic               bit_o,
    output logic [MAX_LEN-1:0] rx_word_o
);
    typedef struct packed {
        logic [MAX_LEN-1:0] tx;
        logic [MAX_LEN-1:0] rx;
        logic [MAX_LEN-1:0] rxo;
    } shf_t;

    shf_t sh_d, sh_q;
    logic [LEN_W-1:0] align_d;

    always_comb begin
        sh_d    = sh_q;
        align_d = LEN_W'(MAX_LEN) - len_i;
        if (load_i) begin
            sh_d.tx = tx_word_i << align_d;
            sh_d.rx = '0;
        end
        if (shift_i) sh_d.tx = sh_q.tx << 1;
        if (sample_i) sh_d.rx = {sh_q.rx[MAX_LEN-2:0], miso_i};
        if (finish_i) sh_d.rxo = sh_q.rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign bit_o     = sh_q.tx[MAX_LEN-1];
    assign rx_word_o = sh_q.rxo;

    // R6
    load_vs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !sample_i && !finish_i);
endmodule

// File: rtl/spim_seq.sv
module spim_seq
    import spim_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned LEN_W = 6,
    localparam int unsigned CW   = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CW-1:0]    hi_i,
    input  logic [CW-1:0]    lo_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             sclk_o,
    output logic             nss_o,
    output logic             oe_o,
    output logic             done_o,
    output logic             busy_o,
    output logic             load_o,
    output logic             shift_o,
    output logic             sample_o,
    output logic             finish_o
);
    typedef struct packed {
        spim_phase_e      ph;
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    hi;
        logic [CW-1:0]    lo;
        logic [LEN_W-1:0] bits;
        logic             sclk;
        logic             nss;
        logic             oe;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        load_o   = 1'b0;
        shift_o  = 1'b0;
        sample_o = 1'b0;
        finish_o = 1'b0;
        unique case (s_q.ph)
            SQ_IDLE: begin
                if (start_i) begin
                    load_o   = 1'b1;
                    s_d.ph   = SQ_LEAD;
                    s_d.hi   = hi_i;
                    s_d.lo   = lo_i;
                    s_d.cnt  = hi_i + lo_i - CW'(1);
                    s_d.bits = len_i - LEN_W'(1);
                    s_d.nss  = 1'b0;
                end
            end
            SQ_LEAD: begin
                s_d.cnt = s_q.cnt - CW'(1);
                if (s_q.cnt == s_q.lo) s_d.oe = 1'b1;
                if (s_q.cnt == '0) begin
                    sample_o = 1'b1;
                    s_d.sclk = 1'b1;
                    s_d.ph   = SQ_HIGH;
                    s_d.cnt  = s_q.hi - CW'(1);
                end
            end
            SQ_HIGH: begin
                s_d.cnt = s_q.cnt - CW'(1);
                if (s_q.cnt == '0) begin
                    s_d.sclk = 1'b0;
                    s_d.cnt  = s_q.lo - CW'(1);
                    if (s_q.bits == '0) begin
                        s_d.oe = 1'b0;
                        s_d.ph = SQ_TAIL;
                    end else begin
                        shift_o  = 1'b1;
                        s_d.bits = s_q.bits - LEN_W'(1);
                        s_d.ph   = SQ_LOW;
                    end
                end
            end
            SQ_LOW: begin
                s_d.cnt = s_q.cnt - CW'(1);
                if (s_q.cnt == '0) begin
                    sample_o = 1'b1;
                    s_d.sclk = 1'b1;
                    s_d.ph   = SQ_HIGH;
                    s_d.cnt  = s_q.hi - CW'(1);
                end
            end
            SQ_TAIL: begin
                s_d.cnt = s_q.cnt - CW'(1);
                if (s_q.cnt == '0) begin
                    finish_o = 1'b1;
                    s_d.nss  = 1'b1;
                    s_d.done = 1'b1;
                    s_d.ph   = SQ_IDLE;
                end
            end
            default: s_d.ph = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ph   <= SQ_IDLE;
            s_q.hi   <= CW'(1);
            s_q.lo   <= CW'(1);
            s_q.nss  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o = s_q.sclk;
    assign nss_o  = s_q.nss;
    assign oe_o   = s_q.oe;
    assign done_o = s_q.done;
    assign busy_o = (s_q.ph != SQ_IDLE);

    // R4
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !nss_o);
    // R4
    select_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nss_o) |-> !sclk_o && !oe_o);
    // R7
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> !nss_o);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    done_with_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nss_o) |-> done_o);
    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(s_q.hi) && $stable(s_q.lo));
endmodule

// File: rtl/spim_master.sv
module spim_master #(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned MIN_LEN = 8,
    parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               start_i,
    input  logic [MAX_LEN-1:0] tx_word_i,
    output logic [MAX_LEN-1:0] rx_word_o,
    output logic               done_o,
    output logic               busy_o,
    output logic               sclk_o,
    output logic               nss_o,
    output logic               mosi_o,
    output logic               mosi_oe_o,
    input  logic               miso_i
);
    localparam int unsigned CW = DIV_W + 1;

    logic [CW-1:0]    hi_w, lo_w;
    logic [LEN_W-1:0] len_c;
    logic             load_w, shift_w, sample_w, finish_w, bit_w, oe_w;

    always_comb begin
        if (len_i < LEN_W'(MIN_LEN))      len_c = LEN_W'(MIN_LEN);
        else if (len_i > LEN_W'(MAX_LEN)) len_c = LEN_W'(MAX_LEN);
        else                              len_c = len_i;
    end

    spim_timing #(.DIV_W(DIV_W)) timing_i (
        .div_i (div_i),
        .hi_o  (hi_w),
        .lo_o  (lo_w)
    );

    spim_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .hi_i     (hi_w),
        .lo_i     (lo_w),
        .len_i    (len_c),
        .sclk_o   (sclk_o),
        .nss_o    (nss_o),
        .oe_o     (oe_w),
        .done_o   (done_o),
        .busy_o   (busy_o),
        .load_o   (load_w),
        .shift_o  (shift_w),
        .sample_o (sample_w),
        .finish_o (finish_w)
    );

    spim_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_w),
        .tx_word_i (tx_word_i),
        .len_i     (len_c),
        .shift_i   (shift_w),
        .sample_i  (sample_w),
        .finish_i  (finish_w),
        .miso_i    (miso_i),
        .bit_o     (bit_w),
        .rx_word_o (rx_word_o)
    );

    assign mosi_oe_o = oe_w;
    assign mosi_o    = oe_w ? bit_w : 1'bz;

    // R7
    release_on_last_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mosi_oe_o) |-> $fell(sclk_o));
endmodule

// File: tb/spim_master_tb.sv
module spim_master_tb_top;
    localparam int DIV_W = 8;
    localparam int MAX_LEN = 32;
    localparam int LEN_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic [LEN_W-1:0] len_i = 6'd8;
    logic start_i = 1'b0;
    logic [MAX_LEN-1:0] tx_word_i = '0;
    logic [MAX_LEN-1:0] rx_word_o;
    logic done_o, busy_o, sclk_o, nss_o, mosi_o, mosi_oe_o;
    logic miso_r = 1'b0;

    always #2 clk = ~clk;

    spim_master dut_i (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .len_i(len_i),
        .start_i(start_i), .tx_word_i(tx_word_i), .rx_word_o(rx_word_o),
        .done_o(done_o), .busy_o(busy_o), .sclk_o(sclk_o), .nss_o(nss_o),
        .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_r)
    );

    typedef struct {
        logic [31:0] tx;
        logic [31:0] pat;
        int          len;
        int          div;
    } item_t;

    item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_hi(input int d);
        if (d == 0) return 1;
        if (d % 2 == 1) return (d + 1) / 2;
        return d / 2 + 1;
    endfunction

    function automatic int exp_lo(input int d);
        if (d == 0) return 1;
        if (d % 2 == 1) return (d + 1) / 2;
        return d / 2;
    endfunction

    function automatic string div_req(input int d);
        if (d == 0) return "R3";
        if (d % 2 == 1) return "R2";
        return "R1";
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        if (n >= 32) return 32'hFFFF_FFFF;
        return (32'h1 << n) - 32'h1;
    endfunction

    // monitor / scoreboard
    item_t cur;
    bit    in_frame = 1'b0;
    int    t0, last_rise, last_fall, rises, bit_idx, hh, ll;
    logic [31:0] cap;
    logic  p_nss = 1'b1, p_sclk = 1'b0, p_oe = 1'b0, p_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && p_done)
                chk(1'b0, "R8", "done longer than one cycle", 2, 1);
            if (done_o && !(p_nss == 1'b0 && nss_o == 1'b1))
                chk(1'b0, "R8", "done without select rise", 0, 1);
            if (!in_frame && sclk_o)
                chk(1'b0, "R4", "clock toggles outside word", 1, 0);
            if (p_nss && !nss_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected frame", 1, 0);
                    cur = '{tx: 0, pat: 0, len: 8, div: 0};
                end else begin
                    cur = exp_q.pop_front();
                end
                in_frame = 1'b1;
                t0 = cyc; rises = 0; cap = '0;
                hh = exp_hi(cur.div); ll = exp_lo(cur.div);
                miso_r = cur.pat[cur.len-1];
                bit_idx = cur.len - 2;
            end else if (in_frame) begin
                if (!p_oe && mosi_oe_o)
                    chk(cyc - t0 == hh, "R5", "enable to first bit", cyc - t0, hh);
                if (!p_sclk && sclk_o) begin
                    rises++;
                    if (rises == 1)
                        chk(cyc - t0 == hh + ll, "R4", "select lead", cyc - t0, hh + ll);
                    else
                        chk(cyc - last_fall == ll, div_req(cur.div), "low time",
                            cyc - last_fall, ll);
                    chk(mosi_o !== 1'bz && mosi_o !== 1'bx, "R5", "data valid at rise",
                        0, 1);
                    cap = {cap[30:0], mosi_o};
                    last_rise = cyc;
                end
                if (p_sclk && !sclk_o) begin
                    chk(cyc - last_rise == hh, div_req(cur.div), "high time",
                        cyc - last_rise, hh);
                    last_fall = cyc;
                    if (rises == cur.len) begin
                        chk(!mosi_oe_o && mosi_o === 1'bz, "R7", "release after last bit",
                            mosi_oe_o, 0);
                    end else if (bit_idx >= 0) begin
                        miso_r = cur.pat[bit_idx];
                        bit_idx--;
                    end
                end
                if (!p_nss && nss_o) begin
                    in_frame = 1'b0;
                    chk(cyc - last_fall == ll, "R7", "select hold after last fall",
                        cyc - last_fall, ll);
                    chk(rises == cur.len, "R9", "rising edge count", rises, cur.len);
                    chk(cap == (cur.tx & mask_of(cur.len)), "R5", "transmitted word",
                        cap, cur.tx & mask_of(cur.len));
                    chk(done_o == 1'b1, "R8", "done with select rise", done_o, 1);
                    chk(rx_word_o == (cur.pat & mask_of(cur.len)), "R6", "received word",
                        rx_word_o, cur.pat & mask_of(cur.len));
                end
            end
            p_nss = nss_o; p_sclk = sclk_o; p_oe = mosi_oe_o; p_done = done_o;
        end
    end

    function automatic int clamp_len(input int n);
        if (n < 8) return 8;
        if (n > 32) return 32;
        return n;
    endfunction

    task automatic send(input logic [31:0] tx, input logic [31:0] pat,
                        input int len, input int div);
        item_t it;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        it = '{tx: tx, pat: pat, len: clamp_len(len), div: div};
        exp_q.push_back(it);
        div_i = DIV_W'(div); len_i = LEN_W'(len); tx_word_i = tx; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(nss_o == 1'b1, "R11", "select at reset", nss_o, 1);
        chk(sclk_o == 1'b0, "R11", "clock at reset", sclk_o, 0);
        chk(mosi_o === 1'bz, "R11", "data line at reset", mosi_oe_o, 0);
        chk(!done_o && !busy_o, "R11", "flags at reset", {done_o, busy_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send(32'h0000_00A5, 32'h0000_003C, 8, 0);   wait_done(); // R3
        send(32'h0000_B3C1, 32'h0000_5A0F, 16, 1);  wait_done(); // R2
        send(32'h0000_0096, 32'h0000_00E1, 8, 2);   wait_done(); // R1
        send(32'h0000_0ABC, 32'h0000_0F0F, 12, 5);  wait_done(); // R2
        send(32'hDEAD_BEEF, 32'h1357_9BDF, 32, 6);  wait_done(); // R1
        send(32'h0000_0071, 32'h0000_00C6, 4, 3);   wait_done(); // R9 low clamp
        send(32'hC0FF_EE11, 32'h8421_7BDE, 40, 4);  wait_done(); // R9 high clamp

        // R10: second strobe mid-word is ignored
        send(32'h0000_0355, 32'h0000_02AA, 10, 2);
        repeat (9) @(negedge clk);
        tx_word_i = 32'hFFFF_FFFF; div_i = 8'd0; len_i = 6'd8; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        repeat (20) begin
            chk(nss_o == 1'b1 && !busy_o, "R10", "no word after ignored strobe", nss_o, 1);
            @(negedge clk);
        end
        chk(exp_q.size() == 0, "R10", "scoreboard empty", exp_q.size(), 0);
        finish_run();
    end
endmodule